// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block watches the clock-enable level and the command pins of a synchronous DRAM, clock by clock, and follows which power state the memory is in: normal operation, power-down, self-refresh or clock suspend. It keeps the CKE level of the previous cycle internally. The legality of each command depends on that previous level, the present CKE level, the command and an all-banks-idle status input. The block reports the state and a one-cycle pulse for every entry into and exit from a low-power or suspend state. It also flags illegal commands and reports commands that are dropped while the clock is suspended.

A controller model or a protocol monitor places the block beside the memory interface. Commands accepted in normal operation are passed on as a one-cycle forwarded command. Every output is registered: inputs sampled at one rising edge show their effect right after that edge.

Top module: `sdram_cke_tracker`

## Requirements
- R1: A synchronous active-high reset sets the state to normal, clears every pulse and flag, and sets the stored previous CKE to high. A CKE low in the first cycle after reset therefore counts as a high-to-low drop.
- R2: `state_o` encodes normal=0, power-down=1, self-refresh=2 and clock suspend=3. The six entry/exit pulses are never high together.
- R3: Commands are decoded from {cs_n, ras_n, cas_n, we_n} (bit 3 down to bit 0) as follows: deselect = cs_n high; NOP = 0111; CBR refresh = 0001; mode register set = 0000. Every other pattern with cs_n low is an ordinary command.
- R4: In normal state, a CKE high-to-low drop with all banks idle and a CBR refresh enters self-refresh and pulses `enter_sr_o`.
- R5: In normal state, a CKE high-to-low drop with all banks idle and a deselect or NOP enters power-down and pulses `enter_pd_o`.
- R6: In power-down or self-refresh, while CKE stays low, the state is held whatever the command or idle inputs are, and no flag is raised.
- R7: In power-down or self-refresh, a CKE low-to-high rise returns the state to normal and pulses the matching exit output. The rise is legal only with a deselect or NOP; with any other command `illegal_o` also pulses.
- R8: With a bank active, a CKE drop with CBR refresh raises `illegal_o` and enters clock suspend instead of self-refresh. With a bank active, a mode register set sampled with the previous CKE high raises `illegal_o`. In both cases the command is not forwarded.
- R9: In normal state, any CKE drop not covered by R4 or R5 enters clock suspend and pulses `enter_cs_o`. Clock suspend holds while CKE stays low. A CKE rise returns to normal and pulses `exit_cs_o`.
- R10: During clock suspend, any command with cs_n low is not forwarded and raises `cmd_ignored_o` for one cycle.
- R11: In normal state with the previous CKE high, a legal command with cs_n low drives `fwd_valid_o` high for one cycle, with `fwd_cmd_o` equal to its four pin levels. Otherwise `fwd_cmd_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Current clock-enable level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| all_idle | input | 1 | High when every bank is idle |
| state_o | output | 2 | Current power state (R2 encoding) |
| enter_pd_o | output | 1 | Power-down entry pulse |
| exit_pd_o | output | 1 | Power-down exit pulse |
| enter_sr_o | output | 1 | Self-refresh entry pulse |
| exit_sr_o | output | 1 | Self-refresh exit pulse |
| enter_cs_o | output | 1 | Clock-suspend entry pulse |
| exit_cs_o | output | 1 | Clock-suspend exit pulse |
| illegal_o | output | 1 | Illegal command pulse |
| cmd_ignored_o | output | 1 | Command dropped during clock suspend |
| fwd_valid_o | output | 1 | Forwarded command valid |
| fwd_cmd_o | output | 4 | Forwarded command pin levels |

## Verification
On every cycle, the assertions check that a low-power state holds while CKE is low, that self-refresh is only reached from an idle cycle, that nothing is forwarded out of clock suspend, and that at most one transition pulse fires. Only the bench's scenarios can show the exact next state for each CKE and command pairing, which commands are illegal on a wake-up rise, how active banks turn a self-refresh attempt into suspend, and that the previous-CKE register comes out of reset high.

// File: rtl/sdram_cke_pkg.sv
package sdram_cke_pkg;

   typedef enum logic [1:0] {
      ST_NORMAL = 2'd0,
      ST_PD     = 2'd1,
      ST_SR     = 2'd2,
      ST_SUSP   = 2'd3
   } pwr_state_t;

   typedef struct packed {
      logic desel;
      logic nop;
      logic cbr;
      logic mrs;
   } cmd_class_t;

endpackage

// File: rtl/sct_cmd_decode.sv
module sct_cmd_decode #(
   parameter int CMD_W = 4
) (
   input  logic [CMD_W-1:0]         cmd,
   output sdram_cke_pkg::cmd_class_t cls
);
   localparam int CS_BIT = CMD_W - 1;

   initial begin
      if (CMD_W != 4) $error("sct_cmd_decode: command bus must be 4 bits");
   end

   // R3: bit order {cs_n, ras_n, cas_n, we_n}
   always_comb begin
      cls.desel = cmd[CS_BIT];
      cls.nop   = (cmd == 4'b0111);
      cls.cbr   = (cmd == 4'b0001);
      cls.mrs   = (cmd == 4'b0000);
   end
endmodule

// File: rtl/sct_cke_history.sv
module sct_cke_history #(
   parameter bit PREV_RST = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic cke,
   output logic cke_prev,
   output logic cke_drop,
   output logic cke_rise
);
   always_ff @(posedge clk) begin
      if (rst) cke_prev <= PREV_RST;
      else     cke_prev <= cke;
   end

   assign cke_drop = cke_prev & ~cke;
   assign cke_rise = ~cke_prev & cke;
endmodule

// File: rtl/sct_power_fsm.sv
module sct_power_fsm #(
   parameter int CMD_W = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cke,
   input  logic                      cke_prev,
   input  logic                      cke_drop,
   input  logic                      cke_rise,
   input  logic                      all_idle,
   input  logic [CMD_W-1:0]          cmd,
   input  sdram_cke_pkg::cmd_class_t cls,
   output logic [1:0]                state_o,
   output logic [5:0]                pulse_o,
   output logic                      illegal_o,
   output logic                      ignored_o,
   output logic                      fwd_valid_o,
   output logic [CMD_W-1:0]          fwd_cmd_o
);
   import sdram_cke_pkg::*;

   localparam int NPULSE = 6;
   localparam int P_EPD = 5, P_XPD = 4, P_ESR = 3, P_XSR = 2, P_ECS = 1, P_XCS = 0;

   pwr_state_t        state_q, state_d;
   logic [NPULSE-1:0] pulse_d, pulse_q;
   logic              ill_d, ill_q, ign_d, ign_q, fwd_d, fwd_q;
   logic [CMD_W-1:0]  fcmd_q;
   logic              wake_ok;

   assign wake_ok = cls.desel | cls.nop;

   always_comb begin
      state_d = state_q;
      pulse_d = '0;
      ill_d   = 1'b0;
      ign_d   = 1'b0;
      case (state_q)
         ST_NORMAL: begin
            if (cke_prev && cls.mrs && !all_idle) ill_d = 1'b1;      // R8
            if (cke_drop) begin
               if (all_idle && cls.cbr) begin                        // R4
                  state_d = ST_SR;   pulse_d[P_ESR] = 1'b1;
               end else if (all_idle && wake_ok) begin               // R5
                  state_d = ST_PD;   pulse_d[P_EPD] = 1'b1;
               end else begin                                        // R9
                  state_d = ST_SUSP; pulse_d[P_ECS] = 1'b1;
                  if (cls.cbr) ill_d = 1'b1;                         // R8
               end
            end
         end
         ST_PD: if (cke_rise) begin                                  // R7
            state_d = ST_NORMAL; pulse_d[P_XPD] = 1'b1; ill_d = !wake_ok;
         end
         ST_SR: if (cke_rise) begin                                  // R7
            state_d = ST_NORMAL; pulse_d[P_XSR] = 1'b1; ill_d = !wake_ok;
         end
         default: begin                                              // ST_SUSP
            ign_d = !cls.desel;                                      // R10
            if (cke_rise) begin
               state_d = ST_NORMAL; pulse_d[P_XCS] = 1'b1;
            end
         end
      endcase
      fwd_d = (state_q == ST_NORMAL) && cke_prev && !cls.desel && !ill_d; // R11
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_NORMAL;
         pulse_q <= '0;
         ill_q   <= 1'b0;
         ign_q   <= 1'b0;
         fwd_q   <= 1'b0;
         fcmd_q  <= '0;
      end else begin
         state_q <= state_d;
         pulse_q <= pulse_d;
         ill_q   <= ill_d;
         ign_q   <= ign_d;
         fwd_q   <= fwd_d;
         fcmd_q  <= fwd_d ? cmd : '0;
      end
   end

   assign state_o     = state_q;
   assign pulse_o     = pulse_q;
   assign illegal_o   = ill_q;
   assign ignored_o   = ign_q;
   assign fwd_valid_o = fwd_q;
   assign fwd_cmd_o   = fcmd_q;

   a_r6_pd_hold: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_PD && !cke) |=> (state_q == ST_PD && !ill_q));

   a_r6_sr_hold: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_SR && !cke) |=> (state_q == ST_SR && !ill_q));

   a_r4_sr_from_idle: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_SR && $past(state_q) != ST_SR) |-> $past(all_idle));

   a_r10_no_fwd_in_suspend: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_SUSP) |=> !fwd_q);

   a_r2_pulses_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(pulse_q));
endmodule

// File: rtl/sdram_cke_tracker.sv
module sdram_cke_tracker #(
   parameter int CMD_W    = 4,
   parameter bit PREV_RST = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cke,
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic             all_idle,
   output logic [1:0]       state_o,
   output logic             enter_pd_o,
   output logic             exit_pd_o,
   output logic             enter_sr_o,
   output logic             exit_sr_o,
   output logic             enter_cs_o,
   output logic             exit_cs_o,
   output logic             illegal_o,
   output logic             cmd_ignored_o,
   output logic             fwd_valid_o,
   output logic [CMD_W-1:0] fwd_cmd_o
);
   import sdram_cke_pkg::*;

   logic [CMD_W-1:0] cmd;
   cmd_class_t       cls;
   logic             cke_prev, cke_drop, cke_rise;
   logic [5:0]       pulses;

   assign cmd = {cs_n, ras_n, cas_n, we_n};

   sct_cmd_decode #(.CMD_W(CMD_W)) u_dec (
      .cmd (cmd),
      .cls (cls)
   );

   sct_cke_history #(.PREV_RST(PREV_RST)) u_hist (
      .clk      (clk),
      .rst      (rst),
      .cke      (cke),
      .cke_prev (cke_prev),
      .cke_drop (cke_drop),
      .cke_rise (cke_rise)
   );

   sct_power_fsm #(.CMD_W(CMD_W)) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .cke         (cke),
      .cke_prev    (cke_prev),
      .cke_drop    (cke_drop),
      .cke_rise    (cke_rise),
      .all_idle    (all_idle),
      .cmd         (cmd),
      .cls         (cls),
      .state_o     (state_o),
      .pulse_o     (pulses),
      .illegal_o   (illegal_o),
      .ignored_o   (cmd_ignored_o),
      .fwd_valid_o (fwd_valid_o),
      .fwd_cmd_o   (fwd_cmd_o)
   );

   assign {enter_pd_o, exit_pd_o, enter_sr_o, exit_sr_o, enter_cs_o, exit_cs_o} = pulses;
endmodule

// File: tb/sim_sdram_cke_tracker.sv
module sim_sdram_cke_tracker;
   localparam int PERIOD = 10;

   localparam logic [3:0] DES = 4'b1111, NOP = 4'b0111, CBR = 4'b0001,
                          MRS = 4'b0000, ACT = 4'b0011;
   localparam logic [1:0] SN = 2'd0, SP = 2'd1, SS = 2'd2, SC = 2'd3;
   localparam logic [5:0] P0 = 6'b000000, EPD = 6'b100000, XPD = 6'b010000,
                          ESR = 6'b001000, XSR = 6'b000100,
                          ECS = 6'b000010, XCS = 6'b000001;
   localparam int NV = 22;
   // {cke, cmd, idle, state, pulses, illegal, ignored, fwd}
   localparam logic [16:0] VEC [NV] = '{
      {1'b1, NOP, 1'b1, SN, P0,  1'b0, 1'b0, 1'b1},  // R11
      {1'b1, MRS, 1'b1, SN, P0,  1'b0, 1'b0, 1'b1},  // R3 R11
      {1'b1, MRS, 1'b0, SN, P0,  1'b1, 1'b0, 1'b0},  // R8
      {1'b0, NOP, 1'b1, SP, EPD, 1'b0, 1'b0, 1'b1},  // R5
      {1'b0, ACT, 1'b1, SP, P0,  1'b0, 1'b0, 1'b0},  // R6
      {1'b1, DES, 1'b1, SN, XPD, 1'b0, 1'b0, 1'b0},  // R7
      {1'b0, CBR, 1'b1, SS, ESR, 1'b0, 1'b0, 1'b1},  // R4
      {1'b0, MRS, 1'b0, SS, P0,  1'b0, 1'b0, 1'b0},  // R6
      {1'b1, NOP, 1'b1, SN, XSR, 1'b0, 1'b0, 1'b0},  // R7
      {1'b0, DES, 1'b1, SP, EPD, 1'b0, 1'b0, 1'b0},  // R5
      {1'b1, ACT, 1'b1, SN, XPD, 1'b1, 1'b0, 1'b0},  // R7
      {1'b0, CBR, 1'b1, SS, ESR, 1'b0, 1'b0, 1'b1},  // R4
      {1'b1, MRS, 1'b1, SN, XSR, 1'b1, 1'b0, 1'b0},  // R7
      {1'b0, CBR, 1'b0, SC, ECS, 1'b1, 1'b0, 1'b0},  // R8
      {1'b0, ACT, 1'b0, SC, P0,  1'b0, 1'b1, 1'b0},  // R10
      {1'b0, DES, 1'b0, SC, P0,  1'b0, 1'b0, 1'b0},  // R9
      {1'b1, NOP, 1'b0, SN, XCS, 1'b0, 1'b1, 1'b0},  // R9 R10
      {1'b0, ACT, 1'b1, SC, ECS, 1'b0, 1'b0, 1'b1},  // R9
      {1'b1, DES, 1'b1, SN, XCS, 1'b0, 1'b0, 1'b0},  // R9
      {1'b0, NOP, 1'b0, SC, ECS, 1'b0, 1'b0, 1'b1},  // R9
      {1'b1, DES, 1'b0, SN, XCS, 1'b0, 1'b0, 1'b0},  // R9
      {1'b1, ACT, 1'b0, SN, P0,  1'b0, 1'b0, 1'b1}   // R11
   };

   logic clk = 1'b0, rst = 1'b1, cke = 1'b1, all_idle = 1'b1;
   logic [3:0] cmd = DES;
   logic [1:0] state_o;
   logic enter_pd_o, exit_pd_o, enter_sr_o, exit_sr_o, enter_cs_o, exit_cs_o;
   logic illegal_o, cmd_ignored_o, fwd_valid_o;
   logic [3:0] fwd_cmd_o;
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   sdram_cke_tracker u0 (
      .clk(clk), .rst(rst), .cke(cke),
      .cs_n(cmd[3]), .ras_n(cmd[2]), .cas_n(cmd[1]), .we_n(cmd[0]),
      .all_idle(all_idle), .state_o(state_o),
      .enter_pd_o(enter_pd_o), .exit_pd_o(exit_pd_o),
      .enter_sr_o(enter_sr_o), .exit_sr_o(exit_sr_o),
      .enter_cs_o(enter_cs_o), .exit_cs_o(exit_cs_o),
      .illegal_o(illegal_o), .cmd_ignored_o(cmd_ignored_o),
      .fwd_valid_o(fwd_valid_o), .fwd_cmd_o(fwd_cmd_o)
   );

   task automatic check(input string tag, input logic [10:0] exp, input logic [3:0] exp_cmd);
      logic [10:0] act;
      act = {state_o, enter_pd_o, exit_pd_o, enter_sr_o, exit_sr_o,
             enter_cs_o, exit_cs_o, illegal_o, cmd_ignored_o, fwd_valid_o};
      n_chk++;
      if (act !== exp || fwd_cmd_o !== exp_cmd) begin
         n_bad++;
         $display("FAIL %s: got %b/%b expected %b/%b", tag, act, fwd_cmd_o, exp, exp_cmd);
      end
   endtask

   task automatic step(input logic k, input logic [3:0] c, input logic idle);
      cke = k; cmd = c; all_idle = idle;
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      check("R1 reset state", {SN, P0, 3'b000}, 4'h0);
      for (int i = 0; i < NV; i++) begin
         logic [16:0] v;
         v = VEC[i];
         step(v[16], v[15:12], v[11]);
         check($sformatf("R2-vector %0d", i), v[10:0], v[0] ? v[15:12] : 4'h0);
      end
      // R1: reset while in self-refresh returns to normal with previous CKE high
      step(1'b0, CBR, 1'b1);
      check("R4 enter before reset", {SS, ESR, 3'b001}, CBR);
      rst = 1'b1;
      step(1'b0, ACT, 1'b1);
      rst = 1'b0;
      check("R1 reset from self-refresh", {SN, P0, 3'b000}, 4'h0);
      step(1'b0, NOP, 1'b1);
      check("R1 prev CKE high after reset", {SP, EPD, 3'b001}, NOP);
      // R6: long power-down hold with varied commands
      for (int j = 0; j < 4; j++) begin
         step(1'b0, (j % 2) ? MRS : CBR, j[0]);
         check("R6 power-down hold", {SP, P0, 3'b000}, 4'h0);
      end
      step(1'b1, CBR, 1'b1);
      check("R7 illegal wake with CBR", {SN, XPD, 3'b100}, 4'h0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(PERIOD * 5000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule